// File: doc/BRIEF.md
# Amplifier Fault Latch and Status Register Bank

This block collects protection events from a multi-channel amplifier and makes them visible through a small register file. A bus slave, which is not part of this block, drives the register port. Some inputs are level signals from analog detectors: overtemperature warning levels, overtemperature shutdown, charge-pump and analog-supply undervoltage, per-channel current limiting and per-channel DC offset. The block latches these events into sticky fault registers and also shows them as live status. It applies the protection policy: it raises per-channel hi-Z requests and drives an active-low fault flag and an active-low thermal warning flag.

A sticky fault bit is cleared only by a read of its register that happens while the condition that set it has gone away. Current limiting becomes an overcurrent fault only after it has lasted for a fixed number of ticks without a break. The tick comes from a clock prescaler. A DC offset fault puts its channel in hi-Z unless a per-channel report-only control bit is set. A reading from a separate diagnostic engine is held until the next run completes. Reads can use an auto-incrementing pointer. The pointer does not advance past a fault register, so repeated reads of a fault register keep returning that register.

Register map (3-bit address, data zero-extended):
- 0: global sticky faults.
- 1: channel sticky faults.
- 2: diagnostic result.
- 3: global live status.
- 4: channel live status.
- 5: report-only control.
- 6: fault mask.
- 7: reads zero.

Top module: `amp_fault_regs`

## Requirements
- R1: A sticky fault bit is set on any cycle in which its event input is high, and stays set after the input returns low. In address 0, bit0 is overtemperature shutdown, bit1 is charge-pump undervoltage and bit2 is analog-supply undervoltage. In address 1, bit c is the overcurrent timeout of channel c and bit 4+c is the DC offset of channel c.
- R2: A read of address 0 or 1 returns the value held before the read, then clears only the bits whose condition is absent in the read cycle. A bit whose condition is still present stays set.
- R3: Address 3 shows live inputs with no latching: bits 0..2 are the three warning levels, bit3 is shutdown, bit4 is charge-pump undervoltage and bit5 is analog-supply undervoltage. Address 4 shows hi-Z requests in bits 0..3 and live current limiting in bits 4..7.
- R4: Address 2 is 0 after reset. It loads the diagnostic result input when the done pulse is high, and otherwise keeps its value.
- R5: A read with the sequential flag set uses an internal pointer instead of the address input. After a read of a non-fault register the pointer becomes that address plus one. After a read of address 0 or 1 it stays on that address.
- R6: Charge-pump undervoltage also sets the analog-supply undervoltage sticky bit. Any live supply undervoltage drives all hi-Z requests high.
- R7: A channel whose current limiting stays high for OC_TICKS prescaler ticks gets its overcurrent bit set. A single low cycle restarts the count. The channel's hi-Z request stays high while its overcurrent bit is set.
- R8: A latched DC offset fault drives its channel's hi-Z request high, unless bit c of the report-only control (address 5) is 1. The fault flag is asserted in both cases.
- R9: warn_n is low exactly while warning level 1 is high. Live shutdown drives all hi-Z requests high, and register reads keep working during shutdown.
- R10: fault_n is low while any unmasked sticky bit is set. In mask address 6, bit0 masks global faults, bit1 masks overcurrent and bit2 masks DC offset.
- R11: Addresses 5 and 6 reset to 0, are written by the write port and read back in full. Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_lim | input | NUM_CH | Live current limiting per channel |
| dc_off | input | NUM_CH | Live DC offset detect per channel |
| cp_uv | input | 1 | Charge-pump undervoltage |
| avdd_uv | input | 1 | Analog-supply undervoltage |
| ot_warn | input | 3 | Overtemperature warning levels, thermometer coded |
| ot_shut | input | 1 | Overtemperature shutdown |
| diag_done | input | 1 | Diagnostic run complete pulse |
| diag_res | input | DW | Diagnostic result |
| rd_en | input | 1 | Read strobe |
| rd_seq | input | 1 | Use internal pointer for this read |
| rd_addr | input | AW | Read address |
| rdata | output | DW | Read data, one cycle after strobe |
| rvalid | output | 1 | Read data valid |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| fault_n | output | 1 | Active-low fault flag |
| warn_n | output | 1 | Active-low thermal warning |
| hiz_req | output | NUM_CH | Per-channel force-hi-Z requests |

## Verification
The assertions assume that detector inputs are synchronous levels that change only between clock edges, and that the bus side never raises read and write in a way that depends on same-edge ordering. The bench therefore changes every input on the falling edge and holds each level for at least one full cycle. The assertions on the overcurrent counter assume a prescaler period of at least two cycles, and the bench uses a short period with a small tick limit so that the trip window can be checked exactly. The random phase keeps current limiting low and varies only the DC offset and report-only patterns, so the sticky model stays a closed-form function of the two most recent levels.

// File: rtl/amp_fault_pkg.sv
package amp_fault_pkg;

    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned GLB_W    = 3;

    localparam int unsigned A_FLT_GLB  = 0;
    localparam int unsigned A_FLT_CH   = 1;
    localparam int unsigned A_DIAG     = 2;
    localparam int unsigned A_STAT_GLB = 3;
    localparam int unsigned A_STAT_CH  = 4;
    localparam int unsigned A_RPT_CTRL = 5;
    localparam int unsigned A_MASK     = 6;

    localparam int unsigned MSK_GLB = 0;
    localparam int unsigned MSK_OC  = 1;
    localparam int unsigned MSK_DC  = 2;

    typedef struct packed {
        logic avdd_uv;
        logic cp_uv;
        logic ot_shut;
    } glb_evt_t;

    function automatic logic is_fault_addr(input logic [ADDR_W-1:0] a);
        return (a == ADDR_W'(A_FLT_GLB)) || (a == ADDR_W'(A_FLT_CH));
    endfunction

endpackage

// File: rtl/amp_flt_tick.sv
module amp_flt_tick #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || pre_q == PW'(DIV - 1)) pre_q <= '0;
        else                              pre_q <= pre_q + 1'b1;
    end

    assign tick = (pre_q == PW'(DIV - 1));

endmodule

// File: rtl/amp_flt_persist.sv
module amp_flt_persist #(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic active,
    output logic trip
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active)                       cnt_q <= '0;
        else if (tick && cnt_q != CW'(LIMIT))     cnt_q <= cnt_q + 1'b1;
    end

    assign trip = active && (cnt_q == CW'(LIMIT));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(LIMIT));
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        !active |=> cnt_q == '0);
    a_r7_trip_needs_active: assert property (@(posedge clk) disable iff (rst)
        trip |-> active);

endmodule

// File: rtl/amp_flt_sticky.sv
module amp_flt_sticky #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] live,
    input  logic         rd_clr,
    output logic [W-1:0] q
);
    logic [W-1:0] keep;

    always_comb begin
        keep = rd_clr ? (q & live) : q;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= set | keep;
    end

    a_r1_set_latches: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q & $past(set)) == $past(set));
    a_r2_hold_while_live: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q & $past(q & live)) == $past(q & live));
    a_r1_no_read_no_clear: assert property (@(posedge clk) disable iff (rst)
        !rd_clr |=> (q & $past(q)) == $past(q));

endmodule

// File: rtl/amp_fault_regs.sv
module amp_fault_regs
    import amp_fault_pkg::*;
#(
    parameter int unsigned NUM_CH   = 4,
    parameter int unsigned DW       = 8,
    parameter int unsigned AW       = ADDR_W,
    parameter int unsigned TICK_DIV = 1000,
    parameter int unsigned OC_TICKS = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] cur_lim,
    input  logic [NUM_CH-1:0] dc_off,
    input  logic              cp_uv,
    input  logic              avdd_uv,
    input  logic [2:0]        ot_warn,
    input  logic              ot_shut,
    input  logic              diag_done,
    input  logic [DW-1:0]     diag_res,
    input  logic              rd_en,
    input  logic              rd_seq,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rdata,
    output logic              rvalid,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              fault_n,
    output logic              warn_n,
    output logic [NUM_CH-1:0] hiz_req
);
    localparam int unsigned CH2 = 2 * NUM_CH;

    // ---------------- live event vectors ----------------
    glb_evt_t          glb_evt;
    logic              glb_hiz;
    logic [NUM_CH-1:0] oc_trip;
    logic              tick;

    always_comb begin
        glb_evt.ot_shut = ot_shut;
        glb_evt.cp_uv   = cp_uv;
        glb_evt.avdd_uv = avdd_uv | cp_uv;
    end

    assign glb_hiz = glb_evt.ot_shut | glb_evt.cp_uv | glb_evt.avdd_uv;

    amp_flt_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_oc
        amp_flt_persist #(.LIMIT(OC_TICKS)) u_persist (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .active (cur_lim[c]),
            .trip   (oc_trip[c])
        );
    end

    // ---------------- read address / pointer ----------------
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] eff_addr;
    logic          clr_glb;
    logic          clr_ch;

    assign eff_addr = rd_seq ? ptr_q : rd_addr;
    assign clr_glb  = rd_en && (eff_addr == AW'(A_FLT_GLB));
    assign clr_ch   = rd_en && (eff_addr == AW'(A_FLT_CH));

    always_ff @(posedge clk) begin
        if (rst)        ptr_q <= '0;
        else if (rd_en) ptr_q <= is_fault_addr(ADDR_W'(eff_addr)) ? eff_addr
                                                                    : eff_addr + 1'b1;
    end

    // ---------------- sticky fault registers ----------------
    logic [GLB_W-1:0] flt_glb_q;
    logic [CH2-1:0]   flt_ch_q;
    logic [NUM_CH-1:0] oc_q;
    logic [NUM_CH-1:0] dc_q;

    amp_flt_sticky #(.W(GLB_W)) u_glb_sticky (
        .clk    (clk),
        .rst    (rst),
        .set    (glb_evt),
        .live   (glb_evt),
        .rd_clr (clr_glb),
        .q      (flt_glb_q)
    );

    amp_flt_sticky #(.W(CH2)) u_ch_sticky (
        .clk    (clk),
        .rst    (rst),
        .set    ({dc_off, oc_trip}),
        .live   ({dc_off, cur_lim}),
        .rd_clr (clr_ch),
        .q      (flt_ch_q)
    );

    assign oc_q = flt_ch_q[NUM_CH-1:0];
    assign dc_q = flt_ch_q[CH2-1:NUM_CH];

    // ---------------- diagnostic and control registers ----------------
    logic [DW-1:0] diag_q;
    logic [DW-1:0] rpt_q;
    logic [DW-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            diag_q <= '0;
            rpt_q  <= '0;
            mask_q <= '0;
        end else begin
            if (diag_done) diag_q <= diag_res;
            if (wr_en && wr_addr == AW'(A_RPT_CTRL)) rpt_q  <= wr_data;
            if (wr_en && wr_addr == AW'(A_MASK))     mask_q <= wr_data;
        end
    end

    // ---------------- protection outputs ----------------
    always_comb begin
        hiz_req = {NUM_CH{glb_hiz}} | oc_q | (dc_q & ~rpt_q[NUM_CH-1:0]);
    end

    assign fault_n = !(((|flt_glb_q) && !mask_q[MSK_GLB]) ||
                       ((|oc_q)      && !mask_q[MSK_OC])  ||
                       ((|dc_q)      && !mask_q[MSK_DC]));
    assign warn_n  = !ot_warn[0];

    // ---------------- read mux ----------------
    logic [DW-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        case (eff_addr)
            AW'(A_FLT_GLB):  rd_word = DW'(flt_glb_q);
            AW'(A_FLT_CH):   rd_word = DW'(flt_ch_q);
            AW'(A_DIAG):     rd_word = diag_q;
            AW'(A_STAT_GLB): rd_word = DW'({glb_evt.avdd_uv, glb_evt.cp_uv,
                                            glb_evt.ot_shut, ot_warn});
            AW'(A_STAT_CH):  rd_word = DW'({cur_lim, hiz_req});
            AW'(A_RPT_CTRL): rd_word = rpt_q;
            AW'(A_MASK):     rd_word = mask_q;
            default:         rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_word;
        end
    end

    // ---------------- assertions ----------------
    a_r6_cp_sets_both: assert property (@(posedge clk) disable iff (rst)
        cp_uv |=> flt_glb_q[1] && flt_glb_q[2]);
    a_r6_supply_hiz: assert property (@(posedge clk) disable iff (rst)
        (cp_uv || avdd_uv) |-> (&hiz_req));
    a_r9_shutdown_hiz: assert property (@(posedge clk) disable iff (rst)
        ot_shut |-> (&hiz_req));
    a_r5_fault_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (clr_glb || clr_ch)) |=> ptr_q == $past(eff_addr));
    a_r7_oc_hiz: assert property (@(posedge clk) disable iff (rst)
        ((oc_q & ~hiz_req) == '0));
    a_r10_fault_flag: assert property (@(posedge clk) disable iff (rst)
        ((|oc_q) && !mask_q[MSK_OC]) |-> !fault_n);
    a_r4_diag_hold: assert property (@(posedge clk) disable iff (rst)
        !diag_done |=> $stable(diag_q));

endmodule

// File: tb/amp_fault_regs_tb.sv
module amp_fault_regs_tb;

    localparam int NCH = 4;
    localparam int DIV = 4;
    localparam int LIM = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] cur_lim = '0, dc_off = '0;
    logic           cp_uv = 0, avdd_uv = 0, ot_shut = 0, diag_done = 0;
    logic [2:0]     ot_warn = '0;
    logic [7:0]     diag_res = '0;
    logic           rd_en = 0, rd_seq = 0, wr_en = 0;
    logic [2:0]     rd_addr = '0, wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic [7:0]     rdata;
    logic           rvalid, fault_n, warn_n;
    logic [NCH-1:0] hiz_req;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    amp_fault_regs #(.NUM_CH(NCH), .DW(8), .AW(3), .TICK_DIV(DIV), .OC_TICKS(LIM)) u_dut (
        .clk(clk), .rst(rst), .cur_lim(cur_lim), .dc_off(dc_off), .cp_uv(cp_uv),
        .avdd_uv(avdd_uv), .ot_warn(ot_warn), .ot_shut(ot_shut),
        .diag_done(diag_done), .diag_res(diag_res), .rd_en(rd_en), .rd_seq(rd_seq),
        .rd_addr(rd_addr), .rdata(rdata), .rvalid(rvalid), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .fault_n(fault_n), .warn_n(warn_n),
        .hiz_req(hiz_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // tasks start and end just after a falling edge
    task automatic rd(input logic [2:0] a, input logic seq, output logic [7:0] d);
        rd_en = 1; rd_seq = seq; rd_addr = a;
        @(negedge clk);
        rd_en = 0; rd_seq = 0;
        d = rdata;
        if (rvalid !== 1'b1) chk("R5 rvalid", 32'(rvalid), 1);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        wr_en = 1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_ch_read(input logic [3:0] held, input logic [3:0] r1);
        return {held | r1, 4'b0000};
    endfunction

    function automatic logic [3:0] exp_hiz(input logic [3:0] dcq, input logic [3:0] rpt);
        return dcq & ~rpt;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [3:0] model, rpt, r1, r2;
        void'($urandom(32'd4711));
        cyc(3);
        rst = 0;
        cyc(1);

        // reset state (R11, R4, R10, R9)
        chk("R10 reset fault_n", 32'(fault_n), 1);
        chk("R9 reset warn_n", 32'(warn_n), 1);
        chk("R8 reset hiz", 32'(hiz_req), 0);
        rd(3'd2, 0, d); chk("R4 diag reset", 32'(d), 0);
        rd(3'd5, 0, d); chk("R11 ctrl reset", 32'(d), 0);
        rd(3'd6, 0, d); chk("R11 mask reset", 32'(d), 0);

        // R11 writes and ignored writes
        wr(3'd5, 8'hA0); rd(3'd5, 0, d); chk("R11 ctrl write", 32'(d), 32'hA0);
        wr(3'd1, 8'hFF); rd(3'd1, 0, d); chk("R11 write to fault ignored", 32'(d), 0);
        wr(3'd3, 8'hFF); rd(3'd3, 0, d); chk("R11 write to status ignored", 32'(d), 0);

        // R5 sequential reads over non-fault registers
        rd(3'd4, 0, d);
        rd(3'd0, 1, d); chk("R5 seq to addr5", 32'(d), 32'hA0);
        rd(3'd0, 1, d); chk("R5 seq to addr6", 32'(d), 0);
        wr(3'd5, 8'h00);

        // R4 diagnostic latch
        diag_res = 8'h3C; diag_done = 1; cyc(1); diag_done = 0; diag_res = 8'h81;
        cyc(2);
        rd(3'd2, 0, d); chk("R4 diag holds", 32'(d), 32'h3C);

        // R1/R2/R5/R8 DC offset on ch0, read while active
        dc_off = 4'b0001; cyc(2);
        chk("R8 dc hiz", 32'(hiz_req), 32'h1);
        chk("R10 dc fault_n", 32'(fault_n), 0);
        rd(3'd1, 0, d); chk("R2 read while active", 32'(d), 32'h10);
        rd(3'd0, 1, d); chk("R5 fault ptr holds", 32'(d), 32'h10);
        dc_off = 4'b0000;
        rd(3'd0, 1, d); chk("R1 sticky after removal", 32'(d), 32'h10);
        rd(3'd0, 1, d); chk("R2 cleared after read", 32'(d), 0);
        chk("R8 hiz released", 32'(hiz_req), 0);

        // R8 report-only and R10 mask
        wr(3'd5, 8'h02);
        dc_off = 4'b0010; cyc(1); dc_off = 4'b0000; cyc(1);
        chk("R8 report-only no hiz", 32'(hiz_req), 0);
        chk("R8 report-only still flags", 32'(fault_n), 0);
        wr(3'd6, 8'h04);
        chk("R10 masked dc", 32'(fault_n), 1);
        wr(3'd6, 8'h00);
        rd(3'd1, 0, d); chk("R1 ch1 dc bit", 32'(d), 32'h20);
        wr(3'd5, 8'h00);

        // R6 charge-pump undervoltage
        cp_uv = 1; cyc(1);
        chk("R6 cp hiz all", 32'(hiz_req), 32'hF);
        rd(3'd3, 0, d); chk("R3 live cp status", 32'(d), 32'h30);
        cp_uv = 0; cyc(1);
        rd(3'd0, 0, d); chk("R6 cp sets both", 32'(d), 32'h06);
        rd(3'd0, 0, d); chk("R2 global cleared", 32'(d), 0);
        avdd_uv = 1; cyc(1); avdd_uv = 0; cyc(1);
        rd(3'd0, 0, d); chk("R6 avdd alone", 32'(d), 32'h04);

        // R9 temperature
        ot_warn = 3'b001; cyc(1);
        chk("R9 warn level1", 32'(warn_n), 0);
        ot_warn = 3'b011; ot_shut = 1; cyc(1);
        chk("R9 shutdown hiz", 32'(hiz_req), 32'hF);
        rd(3'd3, 0, d); chk("R3 live temp status", 32'(d), 32'h0B);
        ot_shut = 0; ot_warn = 3'b000; cyc(1);
        chk("R9 warn released", 32'(warn_n), 1);
        rd(3'd0, 0, d); chk("R9 shutdown sticky", 32'(d), 32'h01);
        rd(3'd3, 0, d); chk("R3 status not latched", 32'(d), 0);

        // R7 overcurrent persistence, ch0
        cur_lim = 4'b0001; cyc(LIM * DIV - DIV - 1);
        chk("R7 no early trip", 32'(hiz_req), 0);
        rd(3'd4, 0, d); chk("R3 live cur_lim", 32'(d), 32'h10);
        cyc(DIV + 2);
        chk("R7 trip hiz", 32'(hiz_req), 32'h1);
        rd(3'd1, 0, d); chk("R2 oc read while limiting", 32'(d), 32'h01);
        cur_lim = 4'b0000;
        rd(3'd1, 0, d); chk("R7 oc sticky", 32'(d), 32'h01);
        chk("R7 hiz released", 32'(hiz_req), 0);

        // R7 one-cycle break restarts count
        cur_lim = 4'b0001; cyc(LIM * DIV - DIV - 1);
        cur_lim = 4'b0000; cyc(1);
        cur_lim = 4'b0001; cyc(LIM * DIV - DIV - 1);
        chk("R7 restart no trip", 32'(hiz_req), 0);
        cur_lim = 4'b0000;
        rd(3'd1, 0, d); chk("R7 restart no fault", 32'(d), 0);

        // random DC-offset patterns against a sticky model (R1, R2, R8)
        model = 4'b0000;
        rpt = 4'b0000;
        for (int i = 0; i < 40; i++) begin
            if (i % 10 == 0) begin
                rpt = 4'($urandom);
                wr(3'd5, {4'b0000, rpt});
            end
            r1 = 4'($urandom);
            r2 = 4'($urandom);
            dc_off = r1; cyc(1);
            dc_off = r2;
            rd(3'd1, 0, d);
            chk("R2 random read", 32'(d), 32'(exp_ch_read(model, r1)));
            model = r2;
            chk("R8 random hiz", 32'(hiz_req), 32'(exp_hiz(model, rpt)));
        end
        dc_off = '0; cyc(1);
        rd(3'd1, 0, d);
        rd(3'd1, 0, d); chk("R2 final clear", 32'(d), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule